// File: doc/BRIEF.md
# Lock Contention Limiter Identifier

This block watches a small, fixed set of lock slots and, once per interval, names the thread most likely to be holding up the rest of a parallel program. Every cycle it receives, for each lock slot, a bitmask of the threads currently waiting on that lock. Each slot keeps a running total of waiting thread-cycles. When the interval closes, the totals are frozen into a snapshot and the live counters restart from zero.

A sequential scan then walks the snapshot one slot per cycle and finds the slot with the largest total. The thread recorded as that slot's owner becomes the limiter. The result is held on a thread index output, a one-hot per-thread flag vector and a valid bit, so the memory request scheduler can raise the priority of that thread's requests. A one-cycle done pulse marks each new result. No limiter is reported when nothing waited during the interval, or when the winning slot had no owner.

Top module: `lock_limiter_id`

## Requirements
- R1: Each cycle, every lock slot adds the number of set bits in its waiting mask to its running total. Lock slot l owns bits [l*NUM_THREADS +: NUM_THREADS] of `wait_mask`. The cycle in which `interval_end` is accepted counts toward the interval it closes.
- R2: A running total stops at 2^ACC_W-1 and never wraps.
- R3: An accepted `interval_end` freezes every total into a snapshot and clears the live totals, so the next interval counts from zero.
- R4: Counting from the clock edge that accepts `interval_end`, `search_done` is high for exactly one cycle after NUM_LOCKS edges, and the new result appears on the outputs on that same edge.
- R5: The winning slot is the one with the largest frozen total. `limiter_id` is its owner's thread index, taken from `holder_id[l*TID_W +: TID_W]` at the accepting edge. `limiter_flags` has only bit `limiter_id` set.
- R6: When several slots share the largest total, the one with the lowest index wins.
- R7: When every frozen total is zero, `limiter_valid`, `limiter_id` and `limiter_flags` are all zero.
- R8: When `holder_valid[l]` of the winning slot was low at the accepting edge, `limiter_valid`, `limiter_id` and `limiter_flags` are all zero.
- R9: An `interval_end` that arrives while a scan is running is ignored. The totals keep counting and do not restart.
- R10: After reset, all outputs are zero. The limiter outputs change only on a `search_done` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_end | input | 1 | Closes the current counting interval |
| wait_mask | input | NUM_LOCKS*NUM_THREADS | Per-slot mask of waiting threads |
| holder_valid | input | NUM_LOCKS | Slot currently has an owner |
| holder_id | input | NUM_LOCKS*TID_W | Owner thread index per slot |
| limiter_valid | output | 1 | A limiter thread is named |
| limiter_id | output | TID_W | Index of the limiter thread |
| limiter_flags | output | NUM_THREADS | One-hot limiter flag per thread |
| search_done | output | 1 | One-cycle pulse when a new result is posted |

## Verification
The hardest case to reach from the ports is a counter at its ceiling. If the counter wrapped instead, a different slot would win. The bench fills one slot with every thread waiting for long enough to pass the ceiling, and builds a second slot up to one below the ceiling, so only saturation decides the winner. A second hard case is an interval closing while the previous scan is still walking the slots. The bench raises `interval_end` during every scan cycle of one search, and its model checks that the counts carry into the following interval.

// File: rtl/lim_pkg.sv
package lim_pkg;
   // Scan controller phases
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;
endpackage

// File: rtl/lim_lock_acc.sv
module lim_lock_acc #(
   parameter int NUM_THREADS = 16,
   parameter int ACC_W       = 20
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic [NUM_THREADS-1:0] wait_bits,
   output logic [ACC_W-1:0]       acc_q,
   output logic [ACC_W-1:0]       acc_next
);
   localparam int CNT_W = $clog2(NUM_THREADS + 1);

   logic [CNT_W-1:0] waiters;
   logic [ACC_W:0]   sum;

   // Count waiting threads this cycle
   always_comb begin
      waiters = '0;
      for (int i = 0; i < NUM_THREADS; i++) begin
         waiters = waiters + CNT_W'(wait_bits[i]);
      end
   end

   // One carry bit is enough: a single step is far below the counter range
   always_comb begin
      sum      = {1'b0, acc_q} + (ACC_W + 1)'(waiters);
      acc_next = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clear) acc_q <= '0;
      else            acc_q <= acc_next;
   end
endmodule

// File: rtl/lim_max_scan.sv
module lim_max_scan
   import lim_pkg::*;
#(
   parameter int NUM_LOCKS   = 8,
   parameter int NUM_THREADS = 16,
   parameter int ACC_W       = 20,
   parameter int TID_W       = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [NUM_LOCKS*ACC_W-1:0] tot_flat,
   input  logic [NUM_LOCKS*TID_W-1:0] hid_flat,
   input  logic [NUM_LOCKS-1:0]       hv,
   output logic                       busy,
   output logic                       done,
   output logic                       res_valid,
   output logic [TID_W-1:0]           res_id,
   output logic [NUM_THREADS-1:0]     res_flags
);
   localparam int IDX_W = $clog2(NUM_LOCKS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LOCKS - 1);

   scan_state_e      state;
   logic [ACC_W-1:0] snap_tot [NUM_LOCKS];
   logic [TID_W-1:0] snap_hid [NUM_LOCKS];
   logic [NUM_LOCKS-1:0] snap_hv;
   logic [IDX_W-1:0] idx;
   logic [ACC_W-1:0] best_tot;
   logic [IDX_W-1:0] best_idx;

   logic [ACC_W-1:0] cand_tot;
   logic [IDX_W-1:0] cand_idx;
   logic             take;
   logic             win_ok;

   assign busy = (state == SCAN_RUN);

   // Strictly-greater keeps the earlier slot on ties
   always_comb begin
      take     = snap_tot[idx] > best_tot;
      cand_tot = take ? snap_tot[idx] : best_tot;
      cand_idx = take ? idx : best_idx;
      win_ok   = (cand_tot != '0) && snap_hv[cand_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SCAN_IDLE;
         idx       <= '0;
         best_tot  <= '0;
         best_idx  <= '0;
         snap_hv   <= '0;
         done      <= 1'b0;
         res_valid <= 1'b0;
         res_id    <= '0;
         res_flags <= '0;
         for (int l = 0; l < NUM_LOCKS; l++) begin
            snap_tot[l] <= '0;
            snap_hid[l] <= '0;
         end
      end else begin
         done <= 1'b0;
         if (state == SCAN_IDLE) begin
            if (start) begin
               state    <= SCAN_RUN;
               idx      <= '0;
               best_tot <= '0;
               best_idx <= '0;
               snap_hv  <= hv;
               for (int l = 0; l < NUM_LOCKS; l++) begin
                  snap_tot[l] <= tot_flat[l*ACC_W +: ACC_W];
                  snap_hid[l] <= hid_flat[l*TID_W +: TID_W];
               end
            end
         end else begin
            best_tot <= cand_tot;
            best_idx <= cand_idx;
            idx      <= idx + 1'b1;
            if (idx == LAST_IDX) begin
               state     <= SCAN_IDLE;
               done      <= 1'b1;
               res_valid <= win_ok;
               res_id    <= win_ok ? snap_hid[cand_idx] : '0;
               res_flags <= win_ok ? (NUM_THREADS'(1) << snap_hid[cand_idx]) : '0;
            end
         end
      end
   end
endmodule

// File: rtl/lock_limiter_id.sv
module lock_limiter_id #(
   parameter int NUM_LOCKS   = 8,
   parameter int NUM_THREADS = 16,
   parameter int ACC_W       = 20,
   parameter int TID_W       = $clog2(NUM_THREADS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             interval_end,
   input  logic [NUM_LOCKS*NUM_THREADS-1:0] wait_mask,
   input  logic [NUM_LOCKS-1:0]             holder_valid,
   input  logic [NUM_LOCKS*TID_W-1:0]       holder_id,
   output logic                             limiter_valid,
   output logic [TID_W-1:0]                 limiter_id,
   output logic [NUM_THREADS-1:0]           limiter_flags,
   output logic                             search_done
);
   localparam int CNT_W = $clog2(NUM_THREADS + 1);

   // Elaboration-time parameter checks
   if (NUM_LOCKS < 2) begin : g_bad_locks
      $error("lock_limiter_id: NUM_LOCKS must be at least 2");
   end
   if (NUM_THREADS < 2 || (NUM_THREADS & (NUM_THREADS - 1)) != 0) begin : g_bad_threads
      $error("lock_limiter_id: NUM_THREADS must be a power of two, at least 2");
   end
   if (ACC_W <= CNT_W) begin : g_bad_accw
      $error("lock_limiter_id: ACC_W must exceed the per-cycle count width");
   end
   if (TID_W != $clog2(NUM_THREADS)) begin : g_bad_tidw
      $error("lock_limiter_id: TID_W must equal clog2(NUM_THREADS)");
   end

   logic                       scan_busy;
   logic                       acc_clear;
   logic [NUM_LOCKS*ACC_W-1:0] acc_flat;
   logic [NUM_LOCKS*ACC_W-1:0] acc_next_flat;

   assign acc_clear = interval_end & ~scan_busy;

   for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
      lim_lock_acc #(
         .NUM_THREADS (NUM_THREADS),
         .ACC_W       (ACC_W)
      ) u_acc (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (acc_clear),
         .wait_bits (wait_mask[l*NUM_THREADS +: NUM_THREADS]),
         .acc_q     (acc_flat[l*ACC_W +: ACC_W]),
         .acc_next  (acc_next_flat[l*ACC_W +: ACC_W])
      );
   end

   lim_max_scan #(
      .NUM_LOCKS   (NUM_LOCKS),
      .NUM_THREADS (NUM_THREADS),
      .ACC_W       (ACC_W),
      .TID_W       (TID_W)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (interval_end),
      .tot_flat  (acc_next_flat),
      .hid_flat  (holder_id),
      .hv        (holder_valid),
      .busy      (scan_busy),
      .done      (search_done),
      .res_valid (limiter_valid),
      .res_id    (limiter_id),
      .res_flags (limiter_flags)
   );
endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
   parameter int NUM_LOCKS   = 8,
   parameter int NUM_THREADS = 16,
   parameter int ACC_W       = 20,
   parameter int TID_W       = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       busy,
   input logic                       clear,
   input logic [NUM_LOCKS*ACC_W-1:0] acc_flat,
   input logic                       limiter_valid,
   input logic [TID_W-1:0]           limiter_id,
   input logic [NUM_THREADS-1:0]     limiter_flags,
   input logic                       search_done
);
   assert_flags_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      limiter_valid |-> ($countones(limiter_flags) == 1) && limiter_flags[limiter_id]);

   assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !limiter_valid |-> (limiter_flags == '0) && (limiter_id == '0));

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      search_done |=> !search_done);

   assert_done_after_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      search_done |-> $past(busy));

   assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !search_done |-> $stable(limiter_valid) && $stable(limiter_id) && $stable(limiter_flags));

   for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_chk
      assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(clear) |-> acc_flat[l*ACC_W +: ACC_W] >= $past(acc_flat[l*ACC_W +: ACC_W]));

      assert_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $past(clear) |-> acc_flat[l*ACC_W +: ACC_W] == '0);
   end
endmodule

bind lock_limiter_id lim_checker #(
   .NUM_LOCKS   (NUM_LOCKS),
   .NUM_THREADS (NUM_THREADS),
   .ACC_W       (ACC_W),
   .TID_W       (TID_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (scan_busy),
   .clear         (acc_clear),
   .acc_flat      (acc_flat),
   .limiter_valid (limiter_valid),
   .limiter_id    (limiter_id),
   .limiter_flags (limiter_flags),
   .search_done   (search_done)
);

// File: tb/sim_lock_limiter_id.sv
`timescale 1ns/1ps
module sim_lock_limiter_id;
   localparam int L    = 4;
   localparam int T    = 8;
   localparam int AW   = 6;
   localparam int TW   = 3;
   localparam int MAXV = (1 << AW) - 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n;
   logic           interval_end;
   logic [L*T-1:0] wait_mask;
   logic [L-1:0]   holder_valid;
   logic [L*TW-1:0] holder_id;
   logic           limiter_valid;
   logic [TW-1:0]  limiter_id;
   logic [T-1:0]   limiter_flags;
   logic           search_done;

   lock_limiter_id #(.NUM_LOCKS(L), .NUM_THREADS(T), .ACC_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
      .wait_mask(wait_mask), .holder_valid(holder_valid), .holder_id(holder_id),
      .limiter_valid(limiter_valid), .limiter_id(limiter_id),
      .limiter_flags(limiter_flags), .search_done(search_done));

   int checks = 0;
   int errors = 0;
   int acc_m [L];
   int snap_m [L];
   int snap_hid [L];
   bit snap_hv [L];
   int scan_left = 0;
   int exp_valid = 0;
   int exp_id = 0;
   int exp_flags = 0;
   string tag = "R10";

   task automatic chk(input string t, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Expected outcome of a scan over the frozen totals
   task automatic resolve();
      int best = 0;
      int bi = 0;
      for (int l = 0; l < L; l++) begin
         if (snap_m[l] > best) begin best = snap_m[l]; bi = l; end
      end
      if (best != 0 && snap_hv[bi]) begin
         exp_valid = 1; exp_id = snap_hid[bi]; exp_flags = 1 << snap_hid[bi];
      end else begin
         exp_valid = 0; exp_id = 0; exp_flags = 0;
      end
   endtask

   // Drive one cycle at the falling edge, update the model, check after the next edge
   task automatic step(input logic [L*T-1:0] m, input logic ie);
      bit started;
      bit done_exp = 0;
      wait_mask = m;
      interval_end = ie;
      started = ie && (scan_left == 0);
      for (int l = 0; l < L; l++) begin
         int nv = acc_m[l] + $countones(m[l*T +: T]);
         if (nv > MAXV) nv = MAXV;
         if (started) begin
            snap_m[l] = nv;
            acc_m[l] = 0;
            snap_hid[l] = int'(holder_id[l*TW +: TW]);
            snap_hv[l] = holder_valid[l];
         end else begin
            acc_m[l] = nv;
         end
      end
      if (!started && scan_left > 0) begin
         scan_left--;
         if (scan_left == 0) begin done_exp = 1; resolve(); end
      end
      if (started) scan_left = L;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "done", int'(search_done), int'(done_exp));
      chk(tag, "valid", int'(limiter_valid), exp_valid);
      chk(tag, "id", int'(limiter_id), exp_id);
      chk(tag, "flags", int'(limiter_flags), exp_flags);
      interval_end = 1'b0;
   endtask

   task automatic close(input logic [L*T-1:0] m);
      step(m, 1'b1);
      for (int i = 0; i < L; i++) step('0, 1'b0);
   endtask

   function automatic logic [L*T-1:0] mk(input logic [T-1:0] a, input logic [T-1:0] b,
                                          input logic [T-1:0] c, input logic [T-1:0] d);
      return {d, c, b, a};
   endfunction

   task automatic set_holders(input int i0, input int i1, input int i2, input int i3,
                              input logic [L-1:0] v);
      holder_id = {TW'(i3), TW'(i2), TW'(i1), TW'(i0)};
      holder_valid = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int l = 0; l < L; l++) acc_m[l] = 0;
      rst_n = 1'b0;
      interval_end = 1'b0;
      wait_mask = '0;
      set_holders(0, 0, 0, 0, '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state
      chk("R10", "reset done", int'(search_done), 0);
      chk("R10", "reset valid", int'(limiter_valid), 0);
      chk("R10", "reset id", int'(limiter_id), 0);
      chk("R10", "reset flags", int'(limiter_flags), 0);

      // R1 R5: sparse random waiting, distinct owners
      tag = "R1 R5";
      set_holders(5, 2, 7, 1, 4'hF);
      for (int i = 0; i < 8; i++) step(L*T'($urandom & $urandom), 1'b0);
      close(L*T'($urandom & $urandom));

      // R3: a heavy interval followed by a light one; no carry-over allowed
      tag = "R3";
      for (int i = 0; i < 6; i++) step(mk(8'hFF, 0, 0, 0), 1'b0);
      close('0);
      set_holders(3, 4, 6, 0, 4'hF);
      for (int i = 0; i < 3; i++) step(mk(0, 0, 8'h01, 0), 1'b0);
      close('0);

      // R6: slots 1 and 2 tie at the top
      tag = "R6";
      set_holders(1, 6, 2, 3, 4'hF);
      for (int i = 0; i < 4; i++) step(mk(8'h03, 8'h0F, 8'hF0, 8'h01), 1'b0);
      close('0);

      // R7: no waiting at all
      tag = "R7";
      for (int i = 0; i < 5; i++) step('0, 1'b0);
      close('0);

      // R8: winner has no owner
      tag = "R8";
      set_holders(2, 3, 4, 5, 4'b0111);
      for (int i = 0; i < 4; i++) step(mk(8'h01, 8'h03, 0, 8'hFF), 1'b0);
      close('0);

      // R2: slot 1 saturates at 63, slot 3 reaches 62
      tag = "R2";
      set_holders(0, 7, 1, 2, 4'hF);
      for (int i = 0; i < 8; i++) step(mk(0, 8'hFF, 0, 8'h7F), 1'b0);
      step(mk(0, 8'hFF, 0, 8'h3F), 1'b0);
      step(mk(0, 8'hFF, 0, 0), 1'b0);
      close('0);

      // R9: interval_end held during a whole scan
      tag = "R9";
      set_holders(4, 1, 3, 6, 4'hF);
      for (int i = 0; i < 3; i++) step(mk(8'h0F, 0, 0, 0), 1'b0);
      step(mk(8'h0F, 0, 0, 0), 1'b1);
      for (int i = 0; i < L; i++) step(mk(0, 0, 8'h07, 0), 1'b1);
      step(mk(0, 0, 0, 8'h01), 1'b0);
      close('0);

      // R4 R1 R5: random intervals of varied length and owners
      tag = "R4 R1 R5";
      for (int n = 0; n < 40; n++) begin
         int len = 1 + ($urandom % 12);
         set_holders($urandom % T, $urandom % T, $urandom % T, $urandom % T,
                     L'($urandom | $urandom));
         for (int i = 0; i < len; i++) step(L*T'($urandom & $urandom & $urandom), 1'b0);
         close(L*T'($urandom & $urandom));
      end

      summary();
   end
endmodule